// File: doc/BRIEF.md
# Transmit Descriptor Low-Watermark Monitor

This block sits beside a transmit descriptor ring. It watches the ring's head and tail pointers and works out how many descriptors are still waiting to be serviced. When that number drops below a programmable low watermark, it raises a one-cycle interrupt pulse.

The same 32-bit control word also carries three engine thresholds and a granularity bit: a prefetch threshold, a host threshold and a write-back threshold. The block turns each threshold into a descriptor count for the fetch and write-back engines. When the granularity bit selects descriptor units, it also raises a flag that tells the write-back engine to return every descriptor. The memory transactions themselves belong to those engines and are not part of this block.

Top module: `txLowWatermark`

## Requirements
- R1: While reset is asserted and right after it, `lowIrq` and `wbAll` are 0 and all three scaled thresholds are 0.
- R2: When the tail is at or ahead of the head, the pending count is tail minus head.
- R3: When the tail has wrapped behind the head, the pending count is tail plus ring size minus head.
- R4: `lowIrq` pulses for exactly one cycle when the pending count goes from at or above the low watermark (control bits 31:25) to strictly below it. A count equal to the watermark does not trigger the pulse. The pulse comes two clock edges after the pointer change.
- R5: While the count stays below the watermark, no further pulse follows. Once the count returns to the watermark or above, the next drop below it pulses again.
- R6: A low watermark of zero never produces a pulse.
- R7: With the granularity bit (bit 24) at 1, the three outputs `fetchThr`, `hostThr` and `wbThr` equal the raw fields at bits 5:0, 13:8 and 21:16, and `wbAll` is 1. The outputs follow a control change one clock edge later.
- R8: With the granularity bit at 0, each output equals its raw field times the number of descriptors per cache line (64-byte lines, 16-byte descriptors, so a factor of 4), and `wbAll` is 0.
- R9: Control bits 7:6, 15:14 and 23:22 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringHead | input | PTR_W | Index of the next descriptor to be serviced |
| ringTail | input | PTR_W | Index one past the last descriptor queued by software |
| ringSize | input | PTR_W+1 | Number of descriptors in the ring (nonzero, larger than both pointers) |
| ctrlWord | input | 32 | Threshold and granularity control word |
| lowIrq | output | 1 | One-cycle low-watermark interrupt pulse |
| fetchThr | output | OUT_W | Prefetch threshold in descriptors |
| hostThr | output | OUT_W | Host threshold in descriptors |
| wbThr | output | OUT_W | Write-back threshold in descriptors |
| wbAll | output | 1 | Write back every descriptor |

## Verification
The interrupt is driven by a slow drain of the head toward the tail. Passing exactly through the watermark value shows that "below" is not confused with "at or below". Continuing to drain after the first pulse separates a true edge detector from a level output. Refilling and draining again shows that the detector re-arms. A wrapped pointer pair checks the modulo distance against the plain subtraction, and a zero watermark checks the disable case. The threshold outputs are tried in both granularity modes and with the reserved bits set and cleared, which separates correct scaling from a swapped or unscaled field and from leakage of the reserved bits.

// File: rtl/txlw_pkg.sv
package txlw_pkg;
  localparam int TH_W  = 6;
  localparam int LOW_W = 7;

  localparam int PREF_LSB = 0;
  localparam int HOST_LSB = 8;
  localparam int WB_LSB   = 16;
  localparam int GRAN_BIT = 24;
  localparam int LOW_LSB  = 25;

  typedef struct packed {
    logic             descMode;
    logic [TH_W-1:0]  prefRaw;
    logic [TH_W-1:0]  hostRaw;
    logic [TH_W-1:0]  wbRaw;
    logic [LOW_W-1:0] lowMark;
  } txlwCfg_t;

  function automatic txlwCfg_t decodeCtrl(input logic [31:0] w);
    txlwCfg_t c;
    c.descMode = w[GRAN_BIT];
    c.prefRaw  = w[PREF_LSB +: TH_W];
    c.hostRaw  = w[HOST_LSB +: TH_W];
    c.wbRaw    = w[WB_LSB +: TH_W];
    c.lowMark  = w[LOW_LSB +: LOW_W];
    return c;
  endfunction
endpackage

// File: rtl/txlwDatapath.sv
module txlwDatapath
  import txlw_pkg::*;
#(
  parameter int PTR_W      = 10,
  parameter int LINE_BYTES = 64,
  parameter int DESC_BYTES = 16,
  localparam int SCALE     = LINE_BYTES / DESC_BYTES,
  localparam int OUT_W     = TH_W + $clog2(SCALE),
  localparam int PEND_W    = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  txlwCfg_t          cfg,
  input  logic [PTR_W-1:0]  ringHead,
  input  logic [PTR_W-1:0]  ringTail,
  input  logic [PEND_W-1:0] ringSize,
  output logic [PEND_W-1:0] pendCnt,
  output logic [OUT_W-1:0]  fetchThr,
  output logic [OUT_W-1:0]  hostThr,
  output logic [OUT_W-1:0]  wbThr
);
  logic [PEND_W-1:0] headX, tailX, distNext;
  logic [TH_W-1:0]   rawThr [3];
  logic [OUT_W-1:0]  scaledThr [3];

  assign headX = {1'b0, ringHead};
  assign tailX = {1'b0, ringTail};

  always_comb begin
    if (tailX >= headX) distNext = tailX - headX;
    else                distNext = tailX + ringSize - headX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else       pendCnt <= distNext;
  end

  assign rawThr[0] = cfg.prefRaw;
  assign rawThr[1] = cfg.hostRaw;
  assign rawThr[2] = cfg.wbRaw;

  for (genvar g = 0; g < 3; g++) begin : gScale
    if (SCALE == 1) begin : gUnit
      assign scaledThr[g] = OUT_W'(rawThr[g]);
    end else begin : gMul
      assign scaledThr[g] = cfg.descMode ? OUT_W'(rawThr[g])
                                         : OUT_W'(rawThr[g]) * OUT_W'(SCALE);
    end
  end

  assign fetchThr = scaledThr[0];
  assign hostThr  = scaledThr[1];
  assign wbThr    = scaledThr[2];

  assert_desc_fits_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.descMode |-> (fetchThr < OUT_W'(1 << TH_W)) && (wbThr < OUT_W'(1 << TH_W)));
  assert_line_multiple_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.descMode |-> ((fetchThr % OUT_W'(SCALE)) == '0) && ((hostThr % OUT_W'(SCALE)) == '0));
  assert_pend_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ringSize != '0) && (headX < ringSize) && (tailX < ringSize) |=> pendCnt < $past(ringSize));
endmodule

// File: rtl/txlwControl.sv
module txlwControl
  import txlw_pkg::*;
#(
  parameter int PTR_W   = 10,
  localparam int PEND_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctrlWord,
  input  logic [PEND_W-1:0] pendCnt,
  output txlwCfg_t          cfg,
  output logic              lowIrq
);
  logic belowNow, belowPrev;

  always_ff @(posedge clk) begin
    if (!rstN) cfg <= '0;
    else       cfg <= decodeCtrl(ctrlWord);
  end

  assign belowNow = (cfg.lowMark != '0) && (pendCnt < PEND_W'(cfg.lowMark));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      belowPrev <= 1'b0;
      lowIrq    <= 1'b0;
    end else begin
      belowPrev <= belowNow;
      lowIrq    <= belowNow && !belowPrev;
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    lowIrq |=> !lowIrq);
  assert_zero_mark_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.lowMark == '0) |=> !lowIrq);
  assert_irq_from_below_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowIrq) |-> $past(pendCnt) < PEND_W'($past(cfg.lowMark)));
endmodule

// File: rtl/txLowWatermark.sv
module txLowWatermark
  import txlw_pkg::*;
#(
  parameter int PTR_W      = 10,
  parameter int LINE_BYTES = 64,
  parameter int DESC_BYTES = 16,
  localparam int SCALE     = LINE_BYTES / DESC_BYTES,
  localparam int OUT_W     = TH_W + $clog2(SCALE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] ringHead,
  input  logic [PTR_W-1:0] ringTail,
  input  logic [PTR_W:0]   ringSize,
  input  logic [31:0]      ctrlWord,
  output logic             lowIrq,
  output logic [OUT_W-1:0] fetchThr,
  output logic [OUT_W-1:0] hostThr,
  output logic [OUT_W-1:0] wbThr,
  output logic             wbAll
);
  txlwCfg_t     cfg;
  logic [PTR_W:0] pendCnt;

  txlwControl #(.PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .pendCnt(pendCnt), .cfg(cfg), .lowIrq(lowIrq)
  );

  txlwDatapath #(.PTR_W(PTR_W), .LINE_BYTES(LINE_BYTES), .DESC_BYTES(DESC_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .ringHead(ringHead), .ringTail(ringTail), .ringSize(ringSize),
    .pendCnt(pendCnt), .fetchThr(fetchThr), .hostThr(hostThr), .wbThr(wbThr)
  );

  assign wbAll = cfg.descMode;
endmodule

// File: tb/txLowWatermark_tb.sv
module txLowWatermark_tb_top;
  localparam int PTR_W = 10;
  localparam int OUT_W = 8;

  logic clk = 0, rstN = 0;
  logic [PTR_W-1:0] ringHead = '0, ringTail = '0;
  logic [PTR_W:0] ringSize = 11'd64;
  logic [31:0] ctrlWord = '0;
  logic lowIrq, wbAll;
  logic [OUT_W-1:0] fetchThr, hostThr, wbThr;

  int tests = 0, fails = 0, irqCount = 0;
  int pendM = 0, lowM = 0, prevM = 0, irqM = 0, gM = 0, pM = 0, hM = 0, wM = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txLowWatermark dut_i (
    .clk(clk), .rstN(rstN), .ringHead(ringHead), .ringTail(ringTail),
    .ringSize(ringSize), .ctrlWord(ctrlWord), .lowIrq(lowIrq),
    .fetchThr(fetchThr), .hostThr(hostThr), .wbThr(wbThr), .wbAll(wbAll)
  );

  function automatic int scaleOf(int raw, int g);
    return g ? raw : raw * 4;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pendM = 0; lowM = 0; prevM = 0; irqM = 0; gM = 0; pM = 0; hM = 0; wM = 0;
    end else begin
      int nb;
      int h, t, s;
      nb = (lowM != 0 && pendM < lowM) ? 1 : 0;
      irqM = (nb && !prevM) ? 1 : 0;
      prevM = nb;
      h = int'(ringHead); t = int'(ringTail); s = int'(ringSize);
      pendM = (t >= h) ? t - h : t + s - h;
      lowM = int'(ctrlWord[31:25]);
      gM = int'(ctrlWord[24]);
      pM = int'(ctrlWord[5:0]); hM = int'(ctrlWord[13:8]); wM = int'(ctrlWord[21:16]);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    if (lowIrq) irqCount++;
    check("R4", "lowIrq vs model", int'(lowIrq), irqM);
    check(gM ? "R7" : "R8", "fetchThr vs model", int'(fetchThr), scaleOf(pM, gM));
    check(gM ? "R7" : "R8", "hostThr vs model", int'(hostThr), scaleOf(hM, gM));
    check(gM ? "R7" : "R8", "wbThr vs model", int'(wbThr), scaleOf(wM, gM));
    check(gM ? "R7" : "R8", "wbAll vs model", int'(wbAll), gM);
  end

  task automatic stepTo(int h, int t, int cycles);
    @(negedge clk);
    ringHead = PTR_W'(h); ringTail = PTR_W'(t);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic pulses(string req, int base, int exp);
    check(req, "pulse count", irqCount - base, exp);
  endtask

  function automatic logic [31:0] mkCtrl(int low, int g, int p, int h, int w);
    return (32'(low) << 25) | (32'(g) << 24) | (32'(w) << 16) | (32'(h) << 8) | 32'(p);
  endfunction

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1", "lowIrq in reset", int'(lowIrq), 0);
    rstN = 1;
    @(negedge clk);
    check("R1", "fetchThr after reset", int'(fetchThr), 0);
    check("R1", "wbAll after reset", int'(wbAll), 0);

    ctrlWord = mkCtrl(8, 1, 5, 9, 17);
    stepTo(0, 20, 4);
    check("R7", "fetchThr desc mode", int'(fetchThr), 5);
    check("R7", "hostThr desc mode", int'(hostThr), 9);
    check("R7", "wbThr desc mode", int'(wbThr), 17);
    check("R7", "wbAll desc mode", int'(wbAll), 1);

    base = irqCount; stepTo(12, 20, 4); pulses("R4", base, 0); // equal to mark
    base = irqCount; stepTo(13, 20, 4); pulses("R4", base, 1); // drops to 7
    base = irqCount; stepTo(15, 20, 3); stepTo(16, 20, 3); pulses("R5", base, 0);
    base = irqCount; stepTo(16, 40, 4); stepTo(34, 40, 4); pulses("R5", base, 1);

    base = irqCount; stepTo(60, 20, 4); pulses("R3", base, 0); // wrapped, 24 pending
    base = irqCount; stepTo(60, 3, 4);  pulses("R3", base, 1); // wrapped, 7 pending

    base = irqCount; stepTo(20, 30, 4); pulses("R2", base, 0);
    base = irqCount; stepTo(22, 30, 4); pulses("R2", base, 0); // 8 pending
    base = irqCount; stepTo(23, 30, 4); pulses("R2", base, 1); // 7 pending

    @(negedge clk); ctrlWord = mkCtrl(8, 0, 5, 9, 17);
    repeat (2) @(negedge clk);
    check("R8", "fetchThr line mode", int'(fetchThr), 20);
    check("R8", "hostThr line mode", int'(hostThr), 36);
    check("R8", "wbThr line mode", int'(wbThr), 68);
    check("R8", "wbAll line mode", int'(wbAll), 0);

    @(negedge clk); ctrlWord = mkCtrl(8, 0, 5, 9, 17) | 32'h00C0_C0C0;
    repeat (2) @(negedge clk);
    check("R9", "fetchThr reserved set", int'(fetchThr), 20);
    check("R9", "hostThr reserved set", int'(hostThr), 36);
    check("R9", "wbThr reserved set", int'(wbThr), 68);
    check("R9", "wbAll reserved set", int'(wbAll), 0);

    @(negedge clk); ctrlWord = mkCtrl(0, 1, 1, 2, 3);
    base = irqCount; stepTo(0, 30, 4); stepTo(28, 30, 4); stepTo(30, 30, 4);
    pulses("R6", base, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog R4 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule